// File: doc/BRIEF.md
# Standby Power Domain Gating Controller

This block sequences the supply of a switchable logic domain that sits beside an always-on domain. The always-on side keeps power in run, idle and standby. Only the switchable side may leave the active state, and it does so only while the core asks for standby. The block drives a main-supply enable, a retention strobe and an isolation strobe for that domain. It also drives per-peripheral clock grants, a one-cycle ready pulse and a two-bit status code.

The block has two standby policies. Static gating applies while `dyn_en` is low. The domain then either stays powered for the whole standby period, if any peripheral has its run-in-standby flag set, or it is parked. Dynamic gating applies while `dyn_en` is high. The domain then wakes whenever a peripheral raises a clock request through an event or a DMA trigger. After the requests go quiet and a hold time has passed, it parks again. Parking normally means retention, which keeps all logic contents. With `off_sel` high, parking removes power completely. Leaving standby always brings the domain back to active.

The power-down order is: cut the grants, raise isolation, raise retention, drop the supply. Power-up runs in the reverse order. It raises the supply and waits `PG_WAIT` cycles for power-good, releases retention, drops isolation, then grants clocks with a ready pulse.

Top module: `swdom_pgate`

## Requirements
- R1: After reset the domain is active: `dom_status`=00, `pwr_en`=1, `ret_en`=0, `iso_en`=0, `rdy`=0, and `clk_gnt` is zero while no request is raised.
- R2: With `dyn_en`=0, `off_sel`=0, `sleep_req`=1 and no `run_stby` bit set, the domain reaches retention three cycles after the request is seen: `dom_status`=01, `pwr_en`=0, `ret_en`=1, `iso_en`=1. Clock requests do not wake it under static gating.
- R3: With `dyn_en`=0 and any `run_stby` bit set, standby keeps the domain active (`iso_en`=0) for the whole standby period.
- R4: When `sleep_req` falls while the domain is parked, the domain returns to active. `rdy` rises PG_WAIT+2 cycles after the drop is sampled, together with `iso_en`=0, `pwr_en`=1, `ret_en`=0 and `dom_status`=00.
- R5: With `dyn_en`=1 in standby, a parked domain wakes when any bit of `evt_req` or `dma_req` is set. Once active, `clk_gnt` bit i equals `evt_req[i] | dma_req[i]`. While any request is held, the domain stays active.
- R6: With `dyn_en`=1 in standby, the domain raises `iso_en` exactly IDLE_CYCLES cycles after the last request clears. A request seen during that count restarts it.
- R7: Power-down raises isolation before retention and retention before the supply drops. Power-up raises the supply while isolation is held, releases retention before isolation, and drops isolation only in the cycle `rdy` is high.
- R8: A sleep exit that arrives while a power-down is in progress lets the domain finish parking (`dom_status`=01 is seen) before it powers straight back up to active.
- R9: With `off_sel`=1, parking turns the domain off: `dom_status`=10, `pwr_en`=0, `ret_en`=0, `iso_en`=1. The power-up from off keeps `ret_en` low throughout.
- R10: `clk_gnt` is zero whenever `iso_en` is 1. `rdy` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_req | input | 1 | Core asks for standby (1) or run (0) |
| dyn_en | input | 1 | 1 selects dynamic gating, 0 static |
| off_sel | input | 1 | 1 parks the domain unpowered instead of in retention |
| run_stby | input | N | Per-peripheral run-in-standby flags |
| evt_req | input | N | Per-peripheral clock requests raised by events |
| dma_req | input | N | Per-peripheral clock requests raised by DMA triggers |
| pwr_en | output | 1 | Main supply enable of the switchable domain |
| ret_en | output | 1 | Retention strobe |
| iso_en | output | 1 | Isolation strobe toward the always-on domain |
| dom_status | output | 2 | 00 supplied, 01 retention, 10 off |
| clk_gnt | output | N | Per-peripheral clock grants |
| rdy | output | 1 | One-cycle pulse when the domain becomes usable |

## Verification
The hardest case to reach is a sleep exit that lands in the middle of a power-down. The window is only two cycles wide. The bench enters static standby with no run-in-standby flag, waits for the sample that shows isolation raised, and drops `sleep_req` on that same negative edge. It then checks that the retention code is still seen before the ready pulse. The idle-hold restart is reached in a similar way: a single-cycle request is injected two cycles into the count, and the drop-to-isolation distance is measured from the last request.

// File: rtl/swpg_pkg.sv
package swpg_pkg;
    typedef enum logic [2:0] {
        ST_ACT,
        ST_ISO,
        ST_SAVE,
        ST_RET,
        ST_OFF,
        ST_PWRUP,
        ST_RESTORE
    } pg_state_e;

    localparam logic [1:0] STAT_ON  = 2'b00;
    localparam logic [1:0] STAT_RET = 2'b01;
    localparam logic [1:0] STAT_OFF = 2'b10;
endpackage

// File: rtl/swpg_req_merge.sv
module swpg_req_merge #(
    parameter int N = 4
) (
    input  logic [N-1:0] evt_req,
    input  logic [N-1:0] dma_req,
    input  logic [N-1:0] run_stby,
    output logic [N-1:0] req,
    output logic         any_req,
    output logic         any_rs
);
    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_or
            assign req[i] = evt_req[i] | dma_req[i];
        end
    endgenerate

    assign any_req = |req;
    assign any_rs  = |run_stby;
endmodule

// File: rtl/swpg_seq.sv
module swpg_seq
    import swpg_pkg::*;
#(
    parameter int IDLE_CYCLES = 4,
    parameter int PG_WAIT     = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sleep_req,
    input  logic      dyn_en,
    input  logic      off_sel,
    input  logic      any_req,
    input  logic      any_rs,
    output pg_state_e st,
    output logic      from_ret,
    output logic      rdy
);
    localparam int MAXC = (IDLE_CYCLES > PG_WAIT) ? IDLE_CYCLES : PG_WAIT;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] IDLE_LAST = CW'(IDLE_CYCLES - 1);
    localparam logic [CW-1:0] PG_LAST   = CW'(PG_WAIT - 1);

    typedef struct packed {
        pg_state_e     st;
        logic [CW-1:0] cnt;
        logic          from_ret;
        logic          rdy;
    } seq_t;

    seq_t s_d, s_q;
    logic wake;

    assign wake = !sleep_req || (dyn_en ? any_req : any_rs);

    always_comb begin
        s_d     = s_q;
        s_d.rdy = 1'b0;
        case (s_q.st)
            ST_ACT: begin
                if (!sleep_req) begin
                    s_d.cnt = '0;
                end else if (!dyn_en) begin
                    s_d.cnt = '0;
                    if (!any_rs) s_d.st = ST_ISO;
                end else if (any_req) begin
                    s_d.cnt = '0;
                end else if (s_q.cnt == IDLE_LAST) begin
                    s_d.cnt = '0;
                    s_d.st  = ST_ISO;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            ST_ISO:  s_d.st = off_sel ? ST_OFF : ST_SAVE;
            ST_SAVE: s_d.st = ST_RET;
            ST_RET, ST_OFF: begin
                if (wake) begin
                    s_d.st       = ST_PWRUP;
                    s_d.cnt      = '0;
                    s_d.from_ret = (s_q.st == ST_RET);
                end
            end
            ST_PWRUP: begin
                if (s_q.cnt == PG_LAST) begin
                    s_d.cnt = '0;
                    s_d.st  = ST_RESTORE;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            ST_RESTORE: begin
                s_d.st       = ST_ACT;
                s_d.rdy      = 1'b1;
                s_d.from_ret = 1'b0;
            end
            default: s_d.st = ST_ACT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_ACT, cnt: '0, from_ret: 1'b0, rdy: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign st       = s_q.st;
    assign from_ret = s_q.from_ret;
    assign rdy      = s_q.rdy;
endmodule

// File: rtl/swpg_out_dec.sv
module swpg_out_dec
    import swpg_pkg::*;
#(
    parameter int N = 4
) (
    input  pg_state_e    st,
    input  logic         from_ret,
    input  logic [N-1:0] req,
    output logic         pwr_en,
    output logic         ret_en,
    output logic         iso_en,
    output logic [1:0]   dom_status,
    output logic [N-1:0] clk_gnt
);
    always_comb begin
        pwr_en     = 1'b1;
        ret_en     = 1'b0;
        iso_en     = 1'b1;
        dom_status = STAT_ON;
        case (st)
            ST_ACT:     iso_en = 1'b0;
            ST_ISO:     ;
            ST_SAVE:    ret_en = 1'b1;
            ST_RET: begin
                pwr_en     = 1'b0;
                ret_en     = 1'b1;
                dom_status = STAT_RET;
            end
            ST_OFF: begin
                pwr_en     = 1'b0;
                dom_status = STAT_OFF;
            end
            ST_PWRUP:   ret_en = from_ret;
            ST_RESTORE: ;
            default:    ;
        endcase
    end

    assign clk_gnt = (st == ST_ACT) ? req : '0;
endmodule

// File: rtl/swdom_pgate.sv
module swdom_pgate
    import swpg_pkg::*;
#(
    parameter int N           = 4,
    parameter int IDLE_CYCLES = 4,
    parameter int PG_WAIT     = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sleep_req,
    input  logic         dyn_en,
    input  logic         off_sel,
    input  logic [N-1:0] run_stby,
    input  logic [N-1:0] evt_req,
    input  logic [N-1:0] dma_req,
    output logic         pwr_en,
    output logic         ret_en,
    output logic         iso_en,
    output logic [1:0]   dom_status,
    output logic [N-1:0] clk_gnt,
    output logic         rdy
);
    logic [N-1:0] req;
    logic         any_req;
    logic         any_rs;
    pg_state_e    st;
    logic         from_ret;

    swpg_req_merge #(.N(N)) u_merge (
        .evt_req  (evt_req),
        .dma_req  (dma_req),
        .run_stby (run_stby),
        .req      (req),
        .any_req  (any_req),
        .any_rs   (any_rs)
    );

    swpg_seq #(.IDLE_CYCLES(IDLE_CYCLES), .PG_WAIT(PG_WAIT)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_req (sleep_req),
        .dyn_en    (dyn_en),
        .off_sel   (off_sel),
        .any_req   (any_req),
        .any_rs    (any_rs),
        .st        (st),
        .from_ret  (from_ret),
        .rdy       (rdy)
    );

    swpg_out_dec #(.N(N)) u_dec (
        .st         (st),
        .from_ret   (from_ret),
        .req        (req),
        .pwr_en     (pwr_en),
        .ret_en     (ret_en),
        .iso_en     (iso_en),
        .dom_status (dom_status),
        .clk_gnt    (clk_gnt)
    );
endmodule

// File: rtl/swdom_pgate_chk.sv
module swdom_pgate_chk #(
    parameter int N = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         sleep_req,
    input logic         dyn_en,
    input logic [N-1:0] run_stby,
    input logic [N-1:0] evt_req,
    input logic [N-1:0] dma_req,
    input logic         pwr_en,
    input logic         ret_en,
    input logic         iso_en,
    input logic [1:0]   dom_status,
    input logic [N-1:0] clk_gnt,
    input logic         rdy
);
    // R7
    ret_rise_under_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ret_en) |-> (iso_en && pwr_en));
    // R7
    pwr_drop_under_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_en) |-> iso_en);
    // R7
    pwr_rise_under_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_en) |-> iso_en);
    // R7
    ret_release_before_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ret_en) |-> (iso_en && pwr_en));
    // R7
    iso_drop_with_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(iso_en) |-> (rdy && pwr_en && !ret_en));
    // R10
    no_gnt_when_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|clk_gnt) |-> !iso_en);
    // R10
    rdy_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdy |=> !rdy);
    // R2
    ret_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dom_status == 2'b01) |-> (!pwr_en && ret_en && iso_en));
    // R9
    off_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dom_status == 2'b10) |-> (!pwr_en && !ret_en && iso_en));
    // R3
    static_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!iso_en && sleep_req && !dyn_en && (|run_stby)) |=> !iso_en);
    // R5
    dyn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!iso_en && sleep_req && dyn_en && (|(evt_req | dma_req))) |=> !iso_en);
endmodule

bind swdom_pgate swdom_pgate_chk #(.N(N)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sleep_req  (sleep_req),
    .dyn_en     (dyn_en),
    .run_stby   (run_stby),
    .evt_req    (evt_req),
    .dma_req    (dma_req),
    .pwr_en     (pwr_en),
    .ret_en     (ret_en),
    .iso_en     (iso_en),
    .dom_status (dom_status),
    .clk_gnt    (clk_gnt),
    .rdy        (rdy)
);

// File: tb/swdom_pgate_tb.sv
`timescale 1ns/1ps
module swdom_pgate_tb;
    localparam int N    = 4;
    localparam int IDLE = 4;
    localparam int PGW  = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sleep_req = 1'b0;
    logic         dyn_en = 1'b0;
    logic         off_sel = 1'b0;
    logic [N-1:0] run_stby = '0;
    logic [N-1:0] evt_req = '0;
    logic [N-1:0] dma_req = '0;
    logic         pwr_en, ret_en, iso_en, rdy;
    logic [1:0]   dom_status;
    logic [N-1:0] clk_gnt;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    swdom_pgate #(.N(N), .IDLE_CYCLES(IDLE), .PG_WAIT(PGW)) u_dut (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .dyn_en(dyn_en),
        .off_sel(off_sel), .run_stby(run_stby), .evt_req(evt_req),
        .dma_req(dma_req), .pwr_en(pwr_en), .ret_en(ret_en), .iso_en(iso_en),
        .dom_status(dom_status), .clk_gnt(clk_gnt), .rdy(rdy)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // count samples until rdy is seen (0 if not within limit)
    task automatic wait_rdy(output int lat);
        lat = 0;
        for (int i = 1; i <= 30; i++) begin
            step(1);
            if (rdy) begin
                lat = i;
                break;
            end
        end
    endtask

    task automatic wait_iso(output int lat);
        lat = 0;
        for (int i = 1; i <= 30; i++) begin
            step(1);
            if (iso_en) begin
                lat = i;
                break;
            end
        end
    endtask

    task automatic t_reset;
        chk("R1 status", dom_status, 0);
        chk("R1 pwr/ret/iso", {pwr_en, ret_en, iso_en}, 3'b100);
        chk("R1 rdy", rdy, 0);
        chk("R1 gnt", clk_gnt, 0);
        evt_req = 4'b0100;
        step(1);
        chk("R5 run-mode gnt", clk_gnt, 4'b0100);
        evt_req = '0;
        step(1);
    endtask

    task automatic t_static_ret;
        dyn_en = 0; off_sel = 0; run_stby = '0; sleep_req = 1;
        step(1);
        chk("R7 iso first", {pwr_en, ret_en, iso_en}, 3'b101);
        step(1);
        chk("R7 ret second", {pwr_en, ret_en, iso_en}, 3'b111);
        step(1);
        chk("R2 retention status", dom_status, 1);
        chk("R2 retention strobes", {pwr_en, ret_en, iso_en}, 3'b011);
        evt_req = 4'b0010;
        step(3);
        chk("R2 request ignored in static", dom_status, 1);
        chk("R10 gnt zero while parked", clk_gnt, 0);
        evt_req = '0;
        step(1);
    endtask

    task automatic t_exit;
        int lat;
        sleep_req = 0;
        wait_rdy(lat);
        chk("R4 rdy latency", lat, PGW + 2);
        chk("R4 active strobes", {pwr_en, ret_en, iso_en}, 3'b100);
        chk("R4 status", dom_status, 0);
        step(1);
        chk("R10 rdy one cycle", rdy, 0);
    endtask

    task automatic t_static_keep;
        int bad = 0;
        dyn_en = 0; run_stby = 4'b0100; sleep_req = 1;
        for (int i = 0; i < 12; i++) begin
            step(1);
            if (iso_en || dom_status != 0) bad++;
        end
        chk("R3 stays active", bad, 0);
        sleep_req = 0; run_stby = '0;
        step(1);
    endtask

    task automatic t_dynamic;
        int lat;
        int bad = 0;
        dyn_en = 1; off_sel = 0; sleep_req = 1;
        wait_iso(lat);
        chk("R6 idle hold on entry", lat, IDLE);
        step(2);
        chk("R2 parked in dynamic", dom_status, 1);
        evt_req = 4'b0001;
        wait_rdy(lat);
        chk("R5 event wake latency", lat, PGW + 2);
        chk("R5 event gnt", clk_gnt, 4'b0001);
        for (int i = 0; i < 10; i++) begin
            step(1);
            if (iso_en) bad++;
        end
        chk("R5 held while requested", bad, 0);
        evt_req = '0;
        wait_iso(lat);
        chk("R6 idle hold after event", lat, IDLE);
        step(2);
        dma_req = 4'b1000;
        wait_rdy(lat);
        chk("R5 dma wake latency", lat, PGW + 2);
        chk("R5 dma gnt", clk_gnt, 4'b1000);
        dma_req = '0;
        step(2);
        chk("R6 still active mid count", iso_en, 0);
        dma_req = 4'b0010;
        step(1);
        dma_req = '0;
        wait_iso(lat);
        chk("R6 count restarts", lat, IDLE);
        step(2);
        sleep_req = 0;
        wait_rdy(lat);
        chk("R4 exit from dynamic", lat, PGW + 2);
        dyn_en = 0;
        step(1);
    endtask

    task automatic t_mid_exit;
        int lat;
        bit saw_ret = 0;
        dyn_en = 0; run_stby = '0; off_sel = 0; sleep_req = 1;
        step(1);
        chk("R8 in power-down", iso_en, 1);
        sleep_req = 0;
        lat = 0;
        for (int i = 1; i <= 30; i++) begin
            step(1);
            if (dom_status == 2'b01) saw_ret = 1;
            if (rdy) begin
                lat = i;
                break;
            end
        end
        chk("R8 retention reached first", saw_ret, 1);
        chk("R8 back to active", lat, PGW + 4);
        step(1);
    endtask

    task automatic t_off;
        int lat;
        int bad = 0;
        dyn_en = 0; run_stby = '0; off_sel = 1; sleep_req = 1;
        step(2);
        chk("R9 off status", dom_status, 2);
        chk("R9 off strobes", {pwr_en, ret_en, iso_en}, 3'b001);
        sleep_req = 0;
        lat = 0;
        for (int i = 1; i <= 30; i++) begin
            step(1);
            if (ret_en) bad++;
            if (rdy) begin
                lat = i;
                break;
            end
        end
        chk("R9 no retention on power-up", bad, 0);
        chk("R9 wake latency", lat, PGW + 2);
        off_sel = 0;
        step(1);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1;
        step(1);
        t_reset();
        t_static_ret();
        t_exit();
        t_static_keep();
        t_dynamic();
        t_mid_exit();
        t_off();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule